// File: doc/BRIEF.md
# Serial Two-Operand Adder

This block adds two unsigned N-bit numbers using a single one-bit full adder. A high `load_i` at a rising clock edge captures both operands into parallel-load shift registers. While `load_i` is low, the registers feed one bit per cycle into the adder, least significant bit first. Zeros enter the vacated top positions.

The adder keeps its carry in a flip-flop, which is fed back on the next cycle. Each sum bit is registered before it enters an (N+1)-bit output shift chain. After the operand's top bit, the adder adds zero plus zero plus the stored carry. That step places the carry-out in the sum's top bit and leaves the stored carry at zero for the next operation. A one-cycle `done_o` pulse marks the cycle in which `sum_o` holds the whole result.

The output chain keeps shifting, so the result is present only during the done cycle. A new load may start in that same cycle.

Top module: `bit_serial_adder`

## Requirements
- R1: At a rising edge with `load_i` high, both operands are captured from `a_i` and `b_i`. The result that follows is computed from exactly those values.
- R2: `sum_o` in the done cycle equals `a_i + b_i` as an (N+1)-bit unsigned value, with the carry-out in bit N. This holds with the full carry chain, for example all ones plus all ones.
- R3: `done_o` is high for exactly one cycle. That cycle follows the (N+2)th consecutive rising edge with `load_i` low after the last edge with `load_i` high.
- R4: While `rst_ni` is low and right after reset, `sum_o` is zero and `done_o` is low. With no load since reset, `done_o` stays low.
- R5: If `load_i` is held high over several edges, the operands present at the last of those edges are used, and R3 timing counts from that edge.
- R6: A load that arrives before the done cycle abandons the operation in flight, and no done pulse appears for it. The stored carry is cleared at that load, so the new result is correct.
- R7: A load placed at the edge that ends the done cycle is accepted. That operation completes with correct timing and a correct result.
- R8: In the cycle after a done cycle, `sum_o` equals the previous result shifted right by one position, with a zero in bit N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | High: capture operands; low: shift one bit per edge |
| a_i | input | N | First operand |
| b_i | input | N | Second operand |
| sum_o | output | N+1 | Output shift chain; holds the full sum when `done_o` is high |
| done_o | output | 1 | One-cycle pulse marking a complete sum on `sum_o` |

## Verification
Two events can fall in the same cycle: the done cycle of one operation, and the load edge of the next. The bench provokes this by raising `load_i` for the next operands while `done_o` is displayed. It checks that the old result is still intact on `sum_o` in that cycle. It also checks that the new operation produces its own pulse and sum exactly N+2 edges later. A second case sends a load in the middle of an operation. The bench judges it by the missing pulse for the abandoned operation and a correct sum for the new one.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
  typedef struct packed {
    logic s;
    logic c;
  } fa_t;

  function automatic fa_t full_add(input logic a, input logic b, input logic c);
    fa_t r;
    r.s = a ^ b ^ c;
    r.c = (a & b) | (a & c) | (b & c);
    return r;
  endfunction
endpackage

// File: rtl/bsa_load_shreg.sv
module bsa_load_shreg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] par_i,
  output logic         bit_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= '0;
    else if (load_i) q <= par_i;
    else             q <= {1'b0, q[W-1:1]};  // zero fill from the top
  end

  assign bit_o = q[0];
endmodule

// File: rtl/bsa_fa_unit.sv
module bsa_fa_unit
  import bsa_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic a_i,
  input  logic b_i,
  output logic sum_o
);
  logic carry_q;
  logic sum_q;
  fa_t  fa;

  assign fa = full_add(a_i, b_i, carry_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      carry_q <= 1'b0;
      sum_q   <= 1'b0;
    end else begin
      carry_q <= clr_i ? 1'b0 : fa.c;  // abandoned op must not leak its carry
      sum_q   <= fa.s;
    end
  end

  assign sum_o = sum_q;
endmodule

// File: rtl/bsa_out_shreg.sv
module bsa_out_shreg #(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bit_i,
  output logic [W-1:0] par_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= {bit_i, q[W-1:1]};
  end

  assign par_o = q;
endmodule

// File: rtl/bsa_done_ctr.sv
module bsa_done_ctr #(
  parameter int N = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic done_o
);
  localparam int DONE_AT = N + 2;
  localparam int IDLE    = N + 3;
  localparam int CW      = $clog2(IDLE + 1);
  localparam logic [CW-1:0] DONE_C = CW'(DONE_AT);
  localparam logic [CW-1:0] IDLE_C = CW'(IDLE);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt <= IDLE_C;
    else if (load_i)        cnt <= '0;
    else if (cnt != IDLE_C) cnt <= cnt + 1'b1;
  end

  assign done_o = (cnt == DONE_C);
endmodule

// File: rtl/bit_serial_adder.sv
module bit_serial_adder #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  output logic [N:0]   sum_o,
  output logic         done_o
);
  localparam int NOPS = 2;
  localparam int SW   = N + 1;

  logic [N-1:0]    op_par [NOPS];
  logic [NOPS-1:0] op_bit;
  logic            sum_bit;

  assign op_par[0] = a_i;
  assign op_par[1] = b_i;

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    bsa_load_shreg #(.W(N)) u_shreg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load_i),
      .par_i  (op_par[g]),
      .bit_o  (op_bit[g])
    );
  end

  bsa_fa_unit u_fa (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (load_i),
    .a_i    (op_bit[0]),
    .b_i    (op_bit[1]),
    .sum_o  (sum_bit)
  );

  bsa_out_shreg #(.W(SW)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bit_i  (sum_bit),
    .par_o  (sum_o)
  );

  bsa_done_ctr #(.N(N)) u_done (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .done_o (done_o)
  );
endmodule

// File: rtl/bsa_chk.sv
module bsa_chk #(
  parameter int N = 8
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       load_i,
  input logic [N:0] sum_o,
  input logic       done_o
);
  localparam int CW = $clog2(N + 4);
  localparam logic [CW-1:0] AT_C   = CW'(N + 2);
  localparam logic [CW-1:0] IDLE_C = CW'(N + 3);

  logic [CW-1:0] since;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              since <= IDLE_C;
    else if (load_i)          since <= '0;
    else if (since != IDLE_C) since <= since + 1'b1;
  end

  // R3
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R3
  done_timing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (since == AT_C));

  // R6
  load_no_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !done_o);

  // R8
  after_done_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (sum_o == {1'b0, $past(sum_o[N:1])}));

  // R4
  reset_state_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (sum_o == '0 && !done_o));
endmodule

bind bit_serial_adder bsa_chk #(.N(N)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .load_i (load_i),
  .sum_o  (sum_o),
  .done_o (done_o)
);

// File: tb/bit_serial_adder_bench.sv
module bit_serial_adder_bench;
  localparam int N = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         load_i = 1'b0;
  logic [N-1:0] a_i = '0;
  logic [N-1:0] b_i = '0;
  logic [N:0]   sum_o;
  logic         done_o;

  int n_chk = 0;
  int n_bad = 0;
  string cur_req = "R4";

  always #5 clk_i = ~clk_i;

  bit_serial_adder #(.N(N)) u_bit_serial_adder (.*);

  // behavioural reference
  int         m_cnt = N + 3;
  logic [N:0] m_sum = '0;
  logic       m_shx = 1'b0;
  logic [N:0] m_shv = '0;

  always @(posedge clk_i) begin
    if (rst_ni) begin
      m_shx <= (m_cnt == N + 2);
      m_shv <= m_sum >> 1;
      if (load_i) begin
        m_cnt <= 0;
        m_sum <= {1'b0, a_i} + {1'b0, b_i};
      end else if (m_cnt < N + 3) begin
        m_cnt <= m_cnt + 1;
      end
    end
  end

  task automatic check(input string req, input logic [N:0] act, input logic [N:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // compare on every cycle, away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni) begin
      check({cur_req, " R3 done"}, {{N{1'b0}}, done_o}, {{N{1'b0}}, m_cnt == N + 2});
      if (m_cnt == N + 2) check({cur_req, " R2 sum"}, sum_o, m_sum);
      if (m_shx) check("R8 shift", sum_o, m_shv);
    end
  end

  task automatic op(input logic [N-1:0] a, input logic [N-1:0] b, input int low_cycles);
    @(negedge clk_i);
    load_i = 1'b1; a_i = a; b_i = b;
    @(negedge clk_i);
    load_i = 1'b0; a_i = ~a; b_i = ~b;  // changes while shifting must not matter (R1)
    repeat (low_cycles - 1) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R4 reset sum", sum_o, '0);
    check("R4 reset done", {{N{1'b0}}, done_o}, '0);
    rst_ni = 1'b1;
    repeat (6) @(negedge clk_i);  // idle: no done expected (R4)

    cur_req = "R1"; op(8'h00, 8'h00, N + 4);
    cur_req = "R2"; op(8'hFF, 8'hFF, N + 4);
    cur_req = "R2"; op(8'hA5, 8'h5A, N + 4);
    cur_req = "R1"; op(8'h01, 8'hFF, N + 4);
    cur_req = "R2"; op(8'h80, 8'h80, N + 4);

    // R5: load held over three edges with changing values
    cur_req = "R5";
    @(negedge clk_i); load_i = 1'b1; a_i = 8'h11; b_i = 8'h22;
    @(negedge clk_i); a_i = 8'hF0; b_i = 8'h0F;
    @(negedge clk_i); a_i = 8'hC3; b_i = 8'h7E;
    @(negedge clk_i); load_i = 1'b0;
    repeat (N + 3) @(negedge clk_i);

    // R6: abort after three shifts with a carry in flight
    cur_req = "R6";
    op(8'hFF, 8'h01, 3);
    op(8'h0F, 8'h01, N + 4);

    // R7: next load at the edge that ends the done cycle
    cur_req = "R7";
    op(8'hFE, 8'h03, N + 2);
    op(8'h7F, 8'h7F, N + 2);
    op(8'hFF, 8'hFF, N + 4);

    repeat (4) @(negedge clk_i);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule